// File: doc/BRIEF.md
# Dual-Width One-Time-Programmable Memory Read Port

This block is the read side of a one-time-programmable memory. Its array can be seen either as 16-bit words or as 8-bit bytes, and a width-select input picks the view each cycle. In byte mode the pin that carries data bit 15 in word mode becomes an input instead. It is the lowest bit of the byte address and chooses which half of the addressed word appears on the low byte lanes. The data bus is modelled as a data-out vector plus a per-lane drive-enable vector, so the high-impedance state is explicit.

Two active-low controls gate the bus. Chip enable selects the device, and output enable gates data onto the lanes. With either one inactive, every lane is released. An identifier flag stands in for the high-voltage sense that a programmer applies. While it is set, the port returns fixed identification codes instead of array data.

A separate programming block fills the array through a write port. An erased cell holds one, and programming can only clear bits. All port outputs are registered: the controls and address sampled at one clock edge show up on the outputs right after that edge.

Top module: `otp_read_port`

## Requirements
- R1: After reset all drive enables are 0 and data is 0; a location never programmed reads 0xFFFF.
- R2: With ce_n_i=0, oe_n_i=0, word_mode_i=1 and id_mode_i=0, the output after the sampling edge is the full 16-bit word at addr_i, with dq_oe_o=0xFFFF.
- R3: With word_mode_i=0 and half_sel_i=0 (enabled, not identifier), dq_o[7:0] carries bits 7..0 of the word at addr_i, and dq_oe_o=0x00FF.
- R4: With word_mode_i=0 and half_sel_i=1, dq_o[7:0] carries bits 15..8 of the word at addr_i, and dq_oe_o=0x00FF; lanes 15..8, including the shared lane 15, are never driven in byte mode.
- R5: ce_n_i=0 with oe_n_i=1 releases every lane (dq_oe_o=0).
- R6: ce_n_i=1 releases every lane whatever oe_n_i, word_mode_i or id_mode_i are.
- R7: With id_mode_i=1 and the port enabled, addr_i[0]=0 returns 0x20 and addr_i[0]=1 returns 0xB1 on dq_o[7:0], with dq_oe_o=0x00FF in either width mode.
- R8: A write with wr_en_i=1 stores old AND wr_data_i, so a programmed zero can never return to one.
- R9: A read and a write to the same word in the same cycle return the contents from before the write; the next read returns the new contents.
- R10: Addresses at or above the WORDS parameter read as 0xFFFF, and writes to them are dropped.
- R11: Every lane whose drive enable is 0 carries 0 on dq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| word_mode_i | input | 1 | 1 = 16-bit word view, 0 = byte view |
| half_sel_i | input | 1 | Byte-mode half select (the shared lane used as input) |
| id_mode_i | input | 1 | Identifier readout request |
| addr_i | input | ADDR_W | Word address |
| dq_o | output | 16 | Data lanes |
| dq_oe_o | output | 16 | Per-lane drive enable |
| wr_en_i | input | 1 | Program strobe from the programming block |
| wr_addr_i | input | ADDR_W | Word address to program |
| wr_data_i | input | 16 | Pattern to program; zeros clear bits |

## Verification
A program strobe and a read can land on the same word in the same clock. The bench provokes this by driving a read of a word together with a write that clears bits of that same word. The scoreboard expects the read to return the contents from before the write, and expects the read in the following cycle to return the cleared value. Width changes between back-to-back cycles, identifier requests while the chip is deselected, and writes outside the array are checked against the same shadow model.

// File: rtl/otp_rd_pkg.sv
package otp_rd_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] MFR_CODE = 8'h20;
  localparam logic [BYTE_W-1:0] DEV_CODE = 8'hB1;

  typedef enum logic [1:0] {
    SEL_OFF  = 2'd0,
    SEL_ID   = 2'd1,
    SEL_WORD = 2'd2,
    SEL_BYTE = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
  parameter int unsigned WORDS  = 1024,
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(WORDS);

  logic [DATA_W-1:0] cells [WORDS];
  logic              wr_ok;
  logic [IDX_W-1:0]  wr_idx, rd_idx;

  assign wr_ok  = wr_en_i && (wr_addr_i < LIMIT);
  assign wr_idx = wr_addr_i[IDX_W-1:0];
  assign rd_idx = rd_addr_i[IDX_W-1:0];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   word_q <= '1;
      else if (wr_ok && (wr_idx == IDX_W'(g)))       word_q <= word_q & wr_data_i;
    end
    assign cells[g] = word_q;
  end

  // erased value outside the populated range
  assign rd_data_o = (rd_addr_i < LIMIT) ? cells[rd_idx] : '1;
endmodule

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
  import otp_rd_pkg::*;
(
  input  logic    ce_n_i,
  input  logic    oe_n_i,
  input  logic    word_mode_i,
  input  logic    id_mode_i,
  output rd_sel_e sel_o
);
  always_comb begin
    if (ce_n_i || oe_n_i) sel_o = SEL_OFF;
    else if (id_mode_i)   sel_o = SEL_ID;
    else if (word_mode_i) sel_o = SEL_WORD;
    else                  sel_o = SEL_BYTE;
  end
endmodule

// File: rtl/otp_lane_steer.sv
module otp_lane_steer
  import otp_rd_pkg::*;
(
  input  rd_sel_e           sel_i,
  input  logic              half_sel_i,
  input  logic              addr0_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] dq_o,
  output logic [DATA_W-1:0] oe_o
);
  localparam logic [DATA_W-1:0] LOW_LANES = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};

  always_comb begin
    dq_o = '0;
    oe_o = '0;
    unique case (sel_i)
      SEL_ID: begin
        dq_o[BYTE_W-1:0] = addr0_i ? DEV_CODE : MFR_CODE;
        oe_o = LOW_LANES;
      end
      SEL_WORD: begin
        dq_o = word_i;
        oe_o = '1;
      end
      SEL_BYTE: begin
        dq_o[BYTE_W-1:0] = half_sel_i ? word_i[DATA_W-1:BYTE_W] : word_i[BYTE_W-1:0];
        oe_o = LOW_LANES;
      end
      default: begin
        dq_o = '0;
        oe_o = '0;
      end
    endcase
  end
endmodule

// File: rtl/otp_read_port.sv
module otp_read_port
  import otp_rd_pkg::*;
#(
  parameter int unsigned WORDS  = 1024,
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  input  logic              word_mode_i,
  input  logic              half_sel_i,
  input  logic              id_mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [15:0]       dq_o,
  output logic [15:0]       dq_oe_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [15:0]       wr_data_i
);
  rd_sel_e           sel;
  logic [DATA_W-1:0] rd_word, dq_d, oe_d;

  otp_cell_array #(.WORDS(WORDS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .rd_addr_i (addr_i),
    .rd_data_o (rd_word)
  );

  otp_mode_decode u_dec (
    .ce_n_i, .oe_n_i, .word_mode_i, .id_mode_i,
    .sel_o (sel)
  );

  otp_lane_steer u_steer (
    .sel_i      (sel),
    .half_sel_i (half_sel_i),
    .addr0_i    (addr_i[0]),
    .word_i     (rd_word),
    .dq_o       (dq_d),
    .oe_o       (oe_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dq_o    <= '0;
      dq_oe_o <= '0;
    end else begin
      dq_o    <= dq_d;
      dq_oe_o <= oe_d;
    end
  end
endmodule

// File: rtl/otp_read_port_chk.sv
module otp_read_port_chk #(
  parameter int unsigned ADDR_W = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_n_i,
  input logic              oe_n_i,
  input logic              word_mode_i,
  input logic              half_sel_i,
  input logic              id_mode_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [15:0]       dq_o,
  input logic [15:0]       dq_oe_o,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [15:0]       wr_data_i
);
  a_r6_deselect_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_n_i |=> (dq_oe_o == 16'h0000));

  a_r5_out_disable_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_n_i && oe_n_i) |=> (dq_oe_o == 16'h0000));

  a_r2_word_all_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_n_i && !oe_n_i && word_mode_i && !id_mode_i) |=> (dq_oe_o == 16'hFFFF));

  a_r4_byte_upper_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_n_i && !oe_n_i && !word_mode_i) |=> (dq_oe_o[15:8] == 8'h00));

  a_r7_mfr_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_n_i && !oe_n_i && id_mode_i && !addr_i[0]) |=> (dq_o[7:0] == 8'h20 && dq_oe_o == 16'h00FF));

  a_r7_dev_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_n_i && !oe_n_i && id_mode_i && addr_i[0]) |=> (dq_o[7:0] == 8'hB1 && dq_oe_o == 16'h00FF));

  a_r11_idle_lanes_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dq_o & ~dq_oe_o) == 16'h0000);
endmodule

bind otp_read_port otp_read_port_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/otp_read_port_bench.sv
module otp_read_port_bench;
  localparam int unsigned WORDS  = 1024;
  localparam int unsigned ADDR_W = 20;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic ce_n_i = 1'b1, oe_n_i = 1'b1, word_mode_i = 1'b1, half_sel_i = 1'b0, id_mode_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0, wr_addr_i = '0;
  logic [15:0] dq_o, dq_oe_o, wr_data_i = '0;
  logic wr_en_i = 1'b0;

  always #5 clk_i = ~clk_i;

  otp_read_port #(.WORDS(WORDS), .ADDR_W(ADDR_W)) u_otp_read_port (.*);

  typedef struct {
    int          tgt;
    logic [15:0] dq;
    logic [15:0] oe;
    string       req;
  } item_t;

  item_t q[$];
  logic [15:0] model [int];
  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic logic [15:0] model_rd(int a);
    if (a >= int'(WORDS)) return 16'hFFFF;
    return model.exists(a) ? model[a] : 16'hFFFF;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, expectation queued for the next edge
  task automatic drive(bit ce_n, bit oe_n, bit wm, bit hs, bit id, int a,
                       bit we, int wa, logic [15:0] wd, string req);
    item_t it;
    logic [15:0] w;
    @(negedge clk_i);
    ce_n_i = ce_n; oe_n_i = oe_n; word_mode_i = wm; half_sel_i = hs; id_mode_i = id;
    addr_i = ADDR_W'(a); wr_en_i = we; wr_addr_i = ADDR_W'(wa); wr_data_i = wd;
    it.tgt = cyc + 1; it.req = req; it.dq = '0; it.oe = '0;
    if (!ce_n && !oe_n) begin
      if (id) begin
        it.dq = a[0] ? 16'h00B1 : 16'h0020; it.oe = 16'h00FF;
      end else begin
        w = model_rd(a);
        if (wm) begin it.dq = w; it.oe = 16'hFFFF; end
        else begin it.dq = {8'h00, hs ? w[15:8] : w[7:0]}; it.oe = 16'h00FF; end
      end
    end
    q.push_back(it);
    if (we && wa < int'(WORDS)) model[wa] = model_rd(wa) & wd;
  endtask

  task automatic rd(bit wm, bit hs, int a, string req);
    drive(0, 0, wm, hs, 0, a, 0, 0, 16'h0, req);
  endtask

  task automatic wr(int a, logic [15:0] d, string req);
    drive(1, 0, 1, 0, 0, 0, 1, a, d, req);
  endtask

  // monitor
  always @(posedge clk_i) begin
    #2;
    while (q.size() > 0 && q[0].tgt == cyc) begin
      item_t it;
      it = q.pop_front();
      check({it.req, " dq"}, dq_o, it.dq);
      check({it.req, " oe"}, dq_oe_o, it.oe);
      check("R11 idle lanes zero", dq_o & ~dq_oe_o, 16'h0000);
    end
  end

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset oe", dq_oe_o, 16'h0000);
    check("R1 reset dq", dq_o, 16'h0000);
    rst_ni = 1'b1;

    rd(1, 0, 5, "R1 erased word");
    wr(5, 16'h1234, "R8 program");
    rd(1, 0, 5, "R8 read programmed");
    wr(5, 16'hFF0F, "R8 program again");
    rd(1, 0, 5, "R8 bits only cleared");
    wr(5, 16'hFFFF, "R8 ones write");
    rd(1, 0, 5, "R8 zero stays zero");
    rd(0, 0, 5, "R3 low byte");
    rd(0, 1, 5, "R4 high byte");
    rd(1, 0, 5, "R2 word after byte");

    drive(0, 0, 1, 0, 0, 10, 1, 10, 16'hA5C3, "R9 same-cycle read old");
    rd(1, 0, 10, "R9 next read new");

    drive(0, 1, 1, 0, 0, 5, 0, 0, 16'h0, "R5 output disable");
    drive(1, 0, 1, 0, 0, 5, 0, 0, 16'h0, "R6 standby");
    drive(1, 1, 0, 1, 1, 1, 0, 0, 16'h0, "R6 standby id");
    drive(0, 1, 1, 0, 1, 0, 0, 0, 16'h0, "R5 disable id");

    drive(0, 0, 1, 0, 1, 0, 0, 0, 16'h0, "R7 mfr code word");
    drive(0, 0, 1, 0, 1, 1, 0, 0, 16'h0, "R7 dev code word");
    drive(0, 0, 0, 1, 1, 0, 0, 0, 16'h0, "R7 mfr code byte");
    drive(0, 0, 0, 0, 1, 5, 0, 0, 16'h0, "R7 dev code byte");

    wr(2000, 16'h0000, "R10 write out of range");
    rd(1, 0, 2000, "R10 read out of range");
    rd(0, 1, 2000, "R10 byte out of range");
    rd(1, 0, 2000 % WORDS, "R10 no alias write");
    rd(1, 0, WORDS - 1, "R1 last erased");
    wr(WORDS - 1, 16'h7E81, "R8 last word");
    rd(1, 0, WORDS - 1, "R2 last word");

    for (int i = 0; i < 16; i++) begin
      int a = (i * 37 + 3) % WORDS;
      logic [15:0] d = 16'((i * 16'h1357) ^ 16'hC3A5);
      wr(a, d, "R8 pattern");
      rd(1, 0, a, "R2 pattern word");
      rd(0, 0, a, "R3 pattern low");
      rd(0, 1, a, "R4 pattern high");
    end

    drive(1, 1, 1, 0, 0, 0, 0, 0, 16'h0, "R6 idle");
    repeat (4) @(negedge clk_i);
    finish_run();
  end
endmodule